// File: doc/BRIEF.md
# Startup Event Sequencer

The sequencer takes a device from configuration into user operation once the configuration length count is reached. From that moment it counts rising edges of the configuration clock, edges of a user clock, and edges that follow an external DoneIn signal. It releases three outputs, each on the event chosen for it: the Done indication, the release of the I/O three-state hold, and the release of the global set/reset.

The block runs on the configuration clock `clk_i`. The user clock is brought in as a data input, passed through a synchronizer and edge-detected, so it must be slower than the configuration clock. DoneIn passes through its own two-flop synchronizer before any event that depends on it is evaluated. A clock-select input and a sync-to-done input together choose which events are legal. An illegal combination raises an error flag and keeps all three outputs in their configuration-state (low) values. Each released output stays high until the next reset, which marks the start of a new configuration.

Top module: `startup_seq`

## Requirements
- R1: Each event select is 4 bits: 0..3 = C1..C4, 4..6 = U2..U4, 7 = DI, 8 = DI+1, 9 = DI+2. Codes 10..15 are undefined and always illegal. `use_uclk_i`=1 selects the user clock as the startup clock, and `sync_done_i`=1 turns sync-to-done on.
- R2: Ck fires at the k-th rising edge of `clk_i`, counting as the first the edge at which `lc_met_i` is first sampled high. Counting continues after that even if `lc_met_i` falls. No output is released before that first edge.
- R3: Uk fires on the k-th user-clock rising edge counted after C1. A rise of `uclk_i` that is first sampled at clock edge r is counted at edge r+2.
- R4: DI fires at the clock edge where the synchronized DoneIn goes high. This is the second `clk_i` edge that samples `done_in_i` high, and C1 must have been reached.
- R5: DI+n fires on the n-th edge of the selected startup clock after synchronized DoneIn is high. That edge is a `clk_i` edge, or a counted user-clock edge when `use_uclk_i`=1.
- R6: Legal Done events by mode are as follows. Configuration clock with sync: C1..C3. Configuration clock without sync: C1..C4. User clock with sync: C1 or U2. User clock without sync: C1 or U2..U4.
- R7: Legal output-release and set/reset-release events by mode are as follows. Configuration clock with sync: C2, C3, DI or DI+1. Configuration clock without sync: C2..C4. User clock with sync: U2, DI, DI+1 or DI+2. User clock without sync: U2..U4.
- R8: When any event select is illegal, `cfg_err_o` is high at once and `done_o`, `oe_o` and `gsr_rel_o` stay low whatever the other inputs do.
- R9: If the user clock never toggles, no output bound to a U event or to a user-clocked DI+n is ever released.
- R10: Reset drives all three outputs low. Once released, an output stays high until reset, even if `lc_met_i` and `done_in_i` fall.
- R11: The four presets release at these events (Done / outputs / set-reset). Configuration clock, no sync: C1/C2/C3. Configuration clock, sync: C1/DI+1/DI+1. User clock, no sync: U2/U3/U4. User clock, sync: U2/DI+1/DI+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset, start of a configuration |
| uclk_i | input | 1 | User clock, sampled as data |
| lc_met_i | input | 1 | Length count reached |
| done_in_i | input | 1 | External DoneIn, asynchronous |
| use_uclk_i | input | 1 | 1 = user clock is the startup clock |
| sync_done_i | input | 1 | 1 = sync-to-done mode |
| done_evt_i | input | 4 | Event select for Done |
| oe_evt_i | input | 4 | Event select for I/O release |
| gsr_evt_i | input | 4 | Event select for set/reset release |
| done_o | output | 1 | Done indication |
| oe_o | output | 1 | I/O three-state released |
| gsr_rel_o | output | 1 | Global set/reset released |
| cfg_err_o | output | 1 | Illegal setting combination |

## Verification
The sequencer is run with the four presets, then with mixed event selections in each clock/sync mode. The stimulus combines a user clock that rises every four cycles with DoneIn raised a few cycles after the length count. Sharing one stimulus lets configuration-clock, user-clock and DoneIn-relative releases be told apart by the edge number at which each output first rises. Illegal and undefined codes, a silent user clock, a length count that is never met, and a release followed by dropped inputs and reset separate the error hold, the never-complete case and the sticky behaviour from normal sequencing.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int EVT_W   = 4;
  localparam int NUM_REL = 3;
  localparam int REL_DONE = 0;
  localparam int REL_OE   = 1;
  localparam int REL_GSR  = 2;

  localparam logic [EVT_W-1:0] EV_C1  = 4'd0;
  localparam logic [EVT_W-1:0] EV_C2  = 4'd1;
  localparam logic [EVT_W-1:0] EV_C3  = 4'd2;
  localparam logic [EVT_W-1:0] EV_C4  = 4'd3;
  localparam logic [EVT_W-1:0] EV_U2  = 4'd4;
  localparam logic [EVT_W-1:0] EV_U3  = 4'd5;
  localparam logic [EVT_W-1:0] EV_U4  = 4'd6;
  localparam logic [EVT_W-1:0] EV_DI  = 4'd7;
  localparam logic [EVT_W-1:0] EV_DI1 = 4'd8;
  localparam logic [EVT_W-1:0] EV_DI2 = 4'd9;
endpackage

// File: rtl/startup_sync.sv
module startup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic pre_o,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign pre_o = st_q[STAGES-2];
  assign q_o   = st_q[STAGES-1];
endmodule

// File: rtl/startup_edge_cnt.sv
module startup_edge_cnt #(
  parameter int MAX_EDGE   = 4,
  parameter bit KEEP_GOING = 1'b0,
  localparam int CNT_W     = $clog2(MAX_EDGE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  // saturating edge counter; KEEP_GOING keeps counting once started
  always_comb begin
    run   = inc_i | (KEEP_GOING && (cnt_q != '0));
    nxt_o = cnt_q;
    if (run && (cnt_q != CNT_W'(MAX_EDGE))) nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end
endmodule

// File: rtl/startup_legal.sv
module startup_legal
  import startup_pkg::*;
(
  input  logic                           use_uclk_i,
  input  logic                           sync_i,
  input  logic [NUM_REL-1:0][EVT_W-1:0]  evt_i,
  output logic                           err_o
);
  function automatic logic done_ok(logic [EVT_W-1:0] e, logic u, logic s);
    case ({u, s})
      2'b01:   return (e == EV_C1) || (e == EV_C2) || (e == EV_C3);
      2'b00:   return (e == EV_C1) || (e == EV_C2) || (e == EV_C3) || (e == EV_C4);
      2'b11:   return (e == EV_C1) || (e == EV_U2);
      default: return (e == EV_C1) || (e == EV_U2) || (e == EV_U3) || (e == EV_U4);
    endcase
  endfunction

  function automatic logic rel_ok(logic [EVT_W-1:0] e, logic u, logic s);
    case ({u, s})
      2'b01:   return (e == EV_C2) || (e == EV_C3) || (e == EV_DI) || (e == EV_DI1);
      2'b00:   return (e == EV_C2) || (e == EV_C3) || (e == EV_C4);
      2'b11:   return (e == EV_U2) || (e == EV_DI) || (e == EV_DI1) || (e == EV_DI2);
      default: return (e == EV_U2) || (e == EV_U3) || (e == EV_U4);
    endcase
  endfunction

  logic [NUM_REL-1:0] ok_v;

  for (genvar g = 0; g < NUM_REL; g++) begin : g_chk
    if (g == REL_DONE) begin : g_done
      assign ok_v[g] = done_ok(evt_i[g], use_uclk_i, sync_i);
    end else begin : g_rel
      assign ok_v[g] = rel_ok(evt_i[g], use_uclk_i, sync_i);
    end
  end

  assign err_o = ~&ok_v;
endmodule

// File: rtl/startup_release.sv
module startup_release
  import startup_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REL-1:0][EVT_W-1:0] evt_i,
  input  logic [CNT_W-1:0]              c_nxt_i,
  input  logic [CNT_W-1:0]              u_nxt_i,
  input  logic [CNT_W-1:0]              d_nxt_i,
  input  logic                          di_hit_i,
  input  logic                          hold_i,
  output logic [NUM_REL-1:0]            rel_o
);
  function automatic logic hit(logic [EVT_W-1:0] e, logic [CNT_W-1:0] c,
                               logic [CNT_W-1:0] u, logic [CNT_W-1:0] d, logic di);
    case (e)
      EV_C1:   return c >= CNT_W'(1);
      EV_C2:   return c >= CNT_W'(2);
      EV_C3:   return c >= CNT_W'(3);
      EV_C4:   return c >= CNT_W'(4);
      EV_U2:   return u >= CNT_W'(2);
      EV_U3:   return u >= CNT_W'(3);
      EV_U4:   return u >= CNT_W'(4);
      EV_DI:   return di;
      EV_DI1:  return d >= CNT_W'(1);
      EV_DI2:  return d >= CNT_W'(2);
      default: return 1'b0;
    endcase
  endfunction

  logic [NUM_REL-1:0] rel_q;

  for (genvar g = 0; g < NUM_REL; g++) begin : g_rel
    logic hit_w;
    assign hit_w = hit(evt_i[g], c_nxt_i, u_nxt_i, d_nxt_i, di_hit_i);

    // set on next-state counts so release lands on the event edge itself
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rel_q[g] <= 1'b0;
      else         rel_q[g] <= rel_q[g] | (~hold_i & hit_w);
    end
  end

  assign rel_o = rel_q & {NUM_REL{~hold_i}};
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int  MAX_EDGE    = 4,
  parameter int  SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(MAX_EDGE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uclk_i,
  input  logic             lc_met_i,
  input  logic             done_in_i,
  input  logic             use_uclk_i,
  input  logic             sync_done_i,
  input  logic [EVT_W-1:0] done_evt_i,
  input  logic [EVT_W-1:0] oe_evt_i,
  input  logic [EVT_W-1:0] gsr_evt_i,
  output logic             done_o,
  output logic             oe_o,
  output logic             gsr_rel_o,
  output logic             cfg_err_o
);
  logic u_pre, u_q, di_pre, di_q;
  logic urise, started, d_tick;
  logic [CNT_W-1:0] c_nxt, u_nxt, d_nxt;
  logic [NUM_REL-1:0][EVT_W-1:0] evt;
  logic [NUM_REL-1:0] rel;

  assign evt[REL_DONE] = done_evt_i;
  assign evt[REL_OE]   = oe_evt_i;
  assign evt[REL_GSR]  = gsr_evt_i;

  // extra stage on the user clock gives the edge-detect history flop
  startup_sync #(.STAGES(SYNC_STAGES + 1)) u_usync (
    .clk_i, .rst_ni, .d_i(uclk_i), .pre_o(u_pre), .q_o(u_q)
  );

  startup_sync #(.STAGES(SYNC_STAGES)) u_dsync (
    .clk_i, .rst_ni, .d_i(done_in_i), .pre_o(di_pre), .q_o(di_q)
  );

  assign urise   = u_pre & ~u_q;
  assign started = (c_nxt != '0);
  assign d_tick  = use_uclk_i ? urise : 1'b1;

  startup_edge_cnt #(.MAX_EDGE(MAX_EDGE), .KEEP_GOING(1'b1)) u_ccnt (
    .clk_i, .rst_ni, .inc_i(lc_met_i), .nxt_o(c_nxt)
  );

  startup_edge_cnt #(.MAX_EDGE(MAX_EDGE), .KEEP_GOING(1'b0)) u_ucnt (
    .clk_i, .rst_ni, .inc_i(urise & started), .nxt_o(u_nxt)
  );

  startup_edge_cnt #(.MAX_EDGE(MAX_EDGE), .KEEP_GOING(1'b0)) u_dcnt (
    .clk_i, .rst_ni, .inc_i(d_tick & di_q & started), .nxt_o(d_nxt)
  );

  startup_legal u_legal (
    .use_uclk_i, .sync_i(sync_done_i), .evt_i(evt), .err_o(cfg_err_o)
  );

  startup_release #(.CNT_W(CNT_W)) u_rel (
    .clk_i, .rst_ni, .evt_i(evt),
    .c_nxt_i(c_nxt), .u_nxt_i(u_nxt), .d_nxt_i(d_nxt),
    .di_hit_i(di_pre & started), .hold_i(cfg_err_o), .rel_o(rel)
  );

  assign done_o    = rel[REL_DONE];
  assign oe_o      = rel[REL_OE];
  assign gsr_rel_o = rel[REL_GSR];
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uclk_i,
  input logic       lc_met_i,
  input logic       done_in_i,
  input logic [3:0] done_evt_i,
  input logic [3:0] oe_evt_i,
  input logic       done_o,
  input logic       oe_o,
  input logic       gsr_rel_o,
  input logic       cfg_err_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= seen_q | lc_met_i;
  end

  // R2: nothing released before the length count has been seen
  a_r2_none_before_met: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!done_o && !oe_o && !gsr_rel_o));

  // R8: an illegal setting keeps every output low
  a_r8_err_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!done_o && !oe_o && !gsr_rel_o));

  // R10: released outputs stay released
  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cfg_err_o) |=> (done_o || cfg_err_o));
  a_r10_oe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !cfg_err_o) |=> (oe_o || cfg_err_o));
  a_r10_gsr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gsr_rel_o && !cfg_err_o) |=> (gsr_rel_o || cfg_err_o));

  // R4: a DI release needs DoneIn sampled high two edges earlier
  a_r4_di_needs_donein: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oe_o) && (oe_evt_i == 4'd7)) |-> $past(done_in_i, 2));

  // R9: a user-clock Done release needs a sampled user-clock high
  a_r9_uclk_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && (done_evt_i >= 4'd4) && (done_evt_i <= 4'd6)) |-> $past(uclk_i, 3));
endmodule

bind startup_seq startup_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .uclk_i(uclk_i), .lc_met_i(lc_met_i),
  .done_in_i(done_in_i), .done_evt_i(done_evt_i), .oe_evt_i(oe_evt_i),
  .done_o(done_o), .oe_o(oe_o), .gsr_rel_o(gsr_rel_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tb_startup_seq.sv
`timescale 1ns/1ps
module tb_startup_seq;
  logic clk = 1'b0;
  logic rst_ni, uclk, lc_met, done_in, use_uclk, sync_done;
  logic [3:0] done_evt, oe_evt, gsr_evt;
  logic done_o, oe_o, gsr_rel_o, cfg_err_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  startup_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .uclk_i(uclk), .lc_met_i(lc_met),
    .done_in_i(done_in), .use_uclk_i(use_uclk), .sync_done_i(sync_done),
    .done_evt_i(done_evt), .oe_evt_i(oe_evt), .gsr_evt_i(gsr_evt),
    .done_o(done_o), .oe_o(oe_o), .gsr_rel_o(gsr_rel_o), .cfg_err_o(cfg_err_o)
  );

  typedef struct packed {
    logic       use_u;
    logic       sync;
    logic [3:0] de;
    logic [3:0] oe;
    logic [3:0] ge;
    logic       uon;
    logic [4:0] ds;
    logic [4:0] ed;
    logic [4:0] eo;
    logic [4:0] eg;
    logic       err;
    logic [3:0] tag;
  } vec_t;

  // expected value = edge number of first release, 0 = never
  localparam vec_t VEC [15] = '{
    '{1'b0, 1'b0, 4'd0,  4'd1, 4'd2, 1'b0, 5'd0, 5'd1, 5'd2,  5'd3,  1'b0, 4'd11}, // R11 cfg clk, no sync
    '{1'b0, 1'b1, 4'd0,  4'd8, 4'd8, 1'b0, 5'd3, 5'd1, 5'd6,  5'd6,  1'b0, 4'd11}, // R11 cfg clk, sync
    '{1'b1, 1'b0, 4'd4,  4'd5, 4'd6, 1'b1, 5'd0, 5'd9, 5'd13, 5'd17, 1'b0, 4'd11}, // R11 user clk, no sync
    '{1'b1, 1'b1, 4'd4,  4'd8, 4'd9, 1'b1, 5'd3, 5'd9, 5'd9,  5'd13, 1'b0, 4'd11}, // R11 user clk, sync
    '{1'b0, 1'b0, 4'd3,  4'd3, 4'd1, 1'b0, 5'd0, 5'd4, 5'd4,  5'd2,  1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 4'd2,  4'd7, 4'd2, 1'b0, 5'd3, 5'd3, 5'd5,  5'd3,  1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 4'd4,  4'd5, 4'd6, 1'b0, 5'd0, 5'd0, 5'd0,  5'd0,  1'b0, 4'd9},  // R9
    '{1'b1, 1'b1, 4'd0,  4'd7, 4'd4, 1'b1, 5'd3, 5'd1, 5'd5,  5'd9,  1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 4'd3,  4'd1, 4'd2, 1'b1, 5'd3, 5'd0, 5'd0,  5'd0,  1'b1, 4'd6},  // R6
    '{1'b0, 1'b0, 4'd0,  4'd7, 4'd2, 1'b0, 5'd3, 5'd0, 5'd0,  5'd0,  1'b1, 4'd7},  // R7
    '{1'b1, 1'b0, 4'd4,  4'd5, 4'd2, 1'b1, 5'd0, 5'd0, 5'd0,  5'd0,  1'b1, 4'd7},  // R7
    '{1'b0, 1'b0, 4'd10, 4'd1, 4'd2, 1'b0, 5'd0, 5'd0, 5'd0,  5'd0,  1'b1, 4'd1},  // R1
    '{1'b1, 1'b1, 4'd0,  4'd9, 4'd8, 1'b1, 5'd0, 5'd1, 5'd0,  5'd0,  1'b0, 4'd5},  // R5
    '{1'b0, 1'b1, 4'd1,  4'd7, 4'd8, 1'b0, 5'd3, 5'd2, 5'd5,  5'd6,  1'b0, 4'd5},  // R5
    '{1'b1, 1'b1, 4'd0,  4'd7, 4'd8, 1'b0, 5'd3, 5'd1, 5'd5,  5'd0,  1'b0, 4'd9}   // R9
  };

  function automatic string tname(int t);
    case (t)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic uu, input logic ss, input logic [3:0] de,
                     input logic [3:0] oe, input logic [3:0] ge, input logic uon,
                     input int ds, input logic met, input int ncyc,
                     output int fd, output int fo, output int fg);
    rst_ni = 1'b0; use_uclk = uu; sync_done = ss;
    done_evt = de; oe_evt = oe; gsr_evt = ge;
    lc_met = 1'b0; uclk = 1'b0; done_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; lc_met = met;
    fd = 0; fo = 0; fg = 0;
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      if (done_o && fd == 0)    fd = n;
      if (oe_o && fo == 0)      fo = n;
      if (gsr_rel_o && fg == 0) fg = n;
      uclk    = uon && (n >= 2) && (((n - 2) % 4) < 2);
      done_in = (ds != 0) && (n >= ds);
    end
  endtask

  initial begin
    int fd, fo, fg;
    rst_ni = 1'b0; uclk = 1'b0; lc_met = 1'b0; done_in = 1'b0;
    use_uclk = 1'b0; sync_done = 1'b0;
    done_evt = 4'd0; oe_evt = 4'd1; gsr_evt = 4'd2;

    // R10: reset state
    repeat (2) @(negedge clk);
    chk("R10", "reset done_o", done_o, 0);
    chk("R10", "reset oe_o", oe_o, 0);
    chk("R10", "reset gsr_rel_o", gsr_rel_o, 0);
    chk("R10", "reset cfg_err_o", cfg_err_o, 0);

    for (int i = 0; i < 15; i++) begin
      vec_t v;
      v = VEC[i];
      run(v.use_u, v.sync, v.de, v.oe, v.ge, v.uon, int'(v.ds), 1'b1, 24, fd, fo, fg);
      chk(tname(int'(v.tag)), $sformatf("vec %0d done edge", i), fd, int'(v.ed));
      chk(tname(int'(v.tag)), $sformatf("vec %0d oe edge", i), fo, int'(v.eo));
      chk(tname(int'(v.tag)), $sformatf("vec %0d gsr edge", i), fg, int'(v.eg));
      chk(tname(int'(v.tag)), $sformatf("vec %0d cfg_err_o", i), cfg_err_o, int'(v.err));
    end

    // R2: length count never met, nothing releases
    run(1'b0, 1'b0, 4'd0, 4'd1, 4'd2, 1'b1, 3, 1'b0, 20, fd, fo, fg);
    chk("R2", "no met done", fd, 0);
    chk("R2", "no met oe", fo, 0);
    chk("R2", "no met gsr", fg, 0);

    // R10: release, then drop inputs, then reset
    run(1'b0, 1'b0, 4'd0, 4'd1, 4'd2, 1'b0, 0, 1'b1, 5, fd, fo, fg);
    lc_met = 1'b0; done_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10", "sticky done_o", done_o, 1);
    chk("R10", "sticky oe_o", oe_o, 1);
    chk("R10", "sticky gsr_rel_o", gsr_rel_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R10", "reset clears done_o", done_o, 0);
    chk("R10", "reset clears oe_o", oe_o, 0);
    chk("R10", "reset clears gsr_rel_o", gsr_rel_o, 0);

    // R8: user clock + sync with Done at U3 (illegal), everything toggling
    run(1'b1, 1'b1, 4'd5, 4'd8, 4'd9, 1'b1, 3, 1'b1, 24, fd, fo, fg);
    chk("R8", "illegal done", fd, 0);
    chk("R8", "illegal oe", fo, 0);
    chk("R8", "illegal gsr", fg, 0);
    chk("R8", "illegal cfg_err_o", cfg_err_o, 1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule